// File: doc/BRIEF.md
# Dual-Bank Edge/Level Interrupt Controller

This block gathers 64 interrupt request lines into two 32-bit banks and drives one interrupt request to the processor. Each bank keeps a set of latched edge events, an enable mask, and a copy of the live input levels. A fixed per-bit configuration, set by parameters, makes each bit either edge-triggered or level-triggered. An edge-triggered bit latches on a rising input and stays latched until software acknowledges it. A level-triggered bit requests service only while its input is high, and software cannot clear it.

Software reaches the banks through a 32-bit register port with a 12-bit address. Data on this port is byte-reversed in both directions. The input lines are numbered in the opposite order to the banks: lines 0 to 31 sit in the bank at the higher address, and lines 32 to 63 sit in the bank at the lower address. The processor request is registered. It is the OR of the two banks' masked requests.

Top module: `dual_bank_irq_ctl`

## Requirements
- R1: Input line N with N below 32 is bit N of bank 1, which sits at addresses 0x20 to 0x2F. Input line N with N of 32 or more is bit N-32 of bank 0, which sits at addresses 0x10 to 0x1F. The bank index is (addr - 0x10) >> 4 in 12-bit arithmetic.
- R2: In each clock cycle the levels register (bank offset 0xC, read only) takes the sampled value of its 32 input lines.
- R3: An edge-triggered bit is set in the events register (bank offset 0x0, read only) when its input rises against the previous cycle's sample. The bit stays set after the input falls.
- R4: A write to bank offset 0x8 clears each events bit that is edge-triggered and written as 1. If a rising edge on a bit arrives in the same cycle as an acknowledge of that bit, the bit ends up set.
- R5: A level-triggered bit never sets in events, and an acknowledge does not affect it. While its input is high it requests service. After reset, bank 0 has no level-triggered bits and bank 1 has the level-triggered bits 0x1FF00000.
- R6: A bank requests service when (events | (levels & level_cfg)) & mask is nonzero. irq_out is the OR of both bank requests, registered one cycle after the state that causes it.
- R7: The mask register sits at bank offset 0x4 and can be read and written. A write to it changes irq_out one cycle after the write cycle. An event that is latched while masked stays latched, and it raises irq_out once it is unmasked.
- R8: Both register write data and register read data are 32-bit byte-swapped: bus byte 0 carries bits 31:24 of the internal value.
- R9: All of the following read as zero: an address outside both banks, any offset other than 0x0, 0x4 and 0xC, and every cycle in which re is low. Writes to an address outside both banks are ignored. Writes to any offset other than 0x4 and 0x8 are ignored.
- R10: Reset clears events, mask and levels in both banks, and it clears irq_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request lines, sampled on each clock |
| addr | input | 12 | Register address |
| wdata | input | 32 | Register write data, byte-reversed on the bus |
| we | input | 1 | Write strobe, one cycle |
| re | input | 1 | Read strobe, enables rdata |
| rdata | output | 32 | Combinational read data, byte-reversed on the bus |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge and a new rising edge on the same bit in the same clock cycle. The bench first latches bit 0 and drops its input. In one cycle it then raises the input again and writes the acknowledge of that bit, and the later read must still show the bit set. A second case needs care: the level-triggered bits must resist an acknowledge and still drive the request. The bench enables one of those bits through a byte-swapped mask value. That value would select a different bit if the swap were missing, so the byte order is checked by its effect on irq_out.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BANK_W    = 32;
    localparam int NUM_BANKS = 2;
    localparam int ADDR_W    = 12;
    localparam int IDX_W     = ADDR_W - 4;
    localparam logic [ADDR_W-1:0] BANK_BASE = 12'h010;

    typedef enum logic [3:0] {
        OFS_EVENTS = 4'h0,
        OFS_MASK   = 4'h4,
        OFS_ACK    = 4'h8,
        OFS_LEVELS = 4'hC
    } reg_ofs_e;

    typedef struct packed {
        logic [BANK_W-1:0] events;
        logic [BANK_W-1:0] mask;
        logic [BANK_W-1:0] levels;
    } bank_state_t;

    function automatic logic [BANK_W-1:0] bswap(input logic [BANK_W-1:0] v);
        logic [BANK_W-1:0] r;
        for (int i = 0; i < BANK_W / 8; i++) begin
            r[i*8 +: 8] = v[(BANK_W/8 - 1 - i)*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter logic [BANK_W-1:0] LVL_CFG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] line_in,
    input  logic              mask_we,
    input  logic              ack_we,
    input  logic [BANK_W-1:0] wval,
    output logic [BANK_W-1:0] events,
    output logic [BANK_W-1:0] mask,
    output logic [BANK_W-1:0] levels,
    output logic              req
);
    bank_state_t       st_d, st_q;
    logic [BANK_W-1:0] rise;
    logic [BANK_W-1:0] clr;

    always_comb begin
        st_d        = st_q;
        rise        = line_in & ~st_q.levels & ~LVL_CFG;
        clr         = ack_we ? (wval & ~LVL_CFG) : '0;
        st_d.levels = line_in;
        if (mask_we) begin
            st_d.mask = wval;
        end
        st_d.events = (st_q.events & ~clr) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign events = st_q.events;
    assign mask   = st_q.mask;
    assign levels = st_q.levels;
    assign req    = |((st_q.events | (st_q.levels & LVL_CFG)) & st_q.mask);

    // R2: levels track the sampled input lines
    a_r2_levels_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> levels == $past(line_in));

    // R3: a latched event is kept unless an acknowledge occurs
    a_r3_event_held: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_we |=> (events & $past(events)) == $past(events));

    // R4: acknowledged bits clear unless a new edge arrives on them
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |=> (events & $past(wval & ~LVL_CFG & ~(line_in & ~levels))) == '0);

    // R5: level-triggered bits never latch as events
    always @(posedge clk) begin
        if (rst_n) begin
            a_r5_level_no_event: assert ((events & LVL_CFG) == '0);
        end
    end
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
    import irqc_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [BANK_W-1:0]                 wdata,
    input  logic                              we,
    input  logic                              re,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0]  ev_i,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0]  mk_i,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0]  lv_i,
    output logic [NUM_BANKS-1:0]              mask_we,
    output logic [NUM_BANKS-1:0]              ack_we,
    output logic [BANK_W-1:0]                 wval,
    output logic [BANK_W-1:0]                 rdata
);
    logic [ADDR_W-1:0] rel;
    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic [3:0]        ofs;
    logic [BANK_W-1:0] rval;

    always_comb begin
        rel  = addr - BANK_BASE;
        idx  = rel[ADDR_W-1:4];
        hit  = idx < IDX_W'(NUM_BANKS);
        ofs  = addr[3:0];
        wval = bswap(wdata);
        rval = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            mask_we[b] = we && hit && (idx == IDX_W'(b)) && (ofs == OFS_MASK);
            ack_we[b]  = we && hit && (idx == IDX_W'(b)) && (ofs == OFS_ACK);
            if (hit && idx == IDX_W'(b)) begin
                case (ofs)
                    OFS_EVENTS: rval = ev_i[b];
                    OFS_MASK:   rval = mk_i[b];
                    OFS_LEVELS: rval = lv_i[b];
                    default:    rval = '0;
                endcase
            end
        end
        rdata = re ? bswap(rval) : '0;
    end

    // R9: a read outside both banks returns zero
    a_r9_bad_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (re && ((addr < BANK_BASE) || (addr >= BANK_BASE + ADDR_W'(NUM_BANKS * 16))))
        |-> rdata == '0);

    // R9: no write strobe reaches a bank outside the decoded window
    a_r9_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mask_we, ack_we}));
endmodule

// File: rtl/dual_bank_irq_ctl.sv
module dual_bank_irq_ctl
    import irqc_pkg::*;
#(
    parameter logic [BANK_W-1:0] LVL_CFG_B0 = 32'h0000_0000,
    parameter logic [BANK_W-1:0] LVL_CFG_B1 = 32'h1FF0_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] irq_in,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BANK_W-1:0]           wdata,
    input  logic                        we,
    input  logic                        re,
    output logic [BANK_W-1:0]           rdata,
    output logic                        irq_out
);
    typedef struct packed {
        logic irq;
    } top_state_t;

    logic [NUM_BANKS-1:0][BANK_W-1:0] ev, mk, lv;
    logic [NUM_BANKS-1:0]             mask_we, ack_we, req;
    logic [BANK_W-1:0]                wval;
    top_state_t                       top_d, top_q;

    irqc_regif u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wdata   (wdata),
        .we      (we),
        .re      (re),
        .ev_i    (ev),
        .mk_i    (mk),
        .lv_i    (lv),
        .mask_we (mask_we),
        .ack_we  (ack_we),
        .wval    (wval),
        .rdata   (rdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] CFG = (b == 0) ? LVL_CFG_B0 : LVL_CFG_B1;
        irqc_bank #(.LVL_CFG(CFG)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (irq_in[(NUM_BANKS-1-b)*BANK_W +: BANK_W]),
            .mask_we (mask_we[b]),
            .ack_we  (ack_we[b]),
            .wval    (wval),
            .events  (ev[b]),
            .mask    (mk[b]),
            .levels  (lv[b]),
            .req     (req[b])
        );
    end

    always_comb begin
        top_d     = top_q;
        top_d.irq = |req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign irq_out = top_q.irq;

    // R6: output follows the bank requests one cycle later
    a_r6_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_out == $past(|req));
endmodule

// File: tb/sim_dual_bank_irq_ctl.sv
module sim_dual_bank_irq_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] v;

    always #10 clk = ~clk;

    dual_bank_irq_ctl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr),
        .wdata(wdata), .we(we), .re(re), .rdata(rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] sw(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        irq_in = '0; we = 0; re = 0;
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] val);
        addr = a; wdata = sw(val); we = 1;
        @(negedge clk);
        we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] val);
        addr = a; re = 1;
        #1 val = sw(rdata);
        @(negedge clk);
        re = 0;
    endtask

    typedef struct packed {
        logic [63:0] pin;
        logic [31:0] m0;
        logic [31:0] m1;
        logic [31:0] ack1;
        logic        exp_irq;
        logic [31:0] exp_ev0;
        logic [31:0] exp_ev1;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{64'h0000_0000_0000_0001, 32'h0, 32'h1,         32'h0,         1'b1, 32'h0, 32'h1},
        '{64'h0000_0000_0000_0001, 32'h0, 32'h1,         32'h1,         1'b0, 32'h0, 32'h0},
        '{64'h0000_0000_0010_0000, 32'h0, 32'h0010_0000, 32'h0010_0000, 1'b1, 32'h0, 32'h0},
        '{64'h0000_0004_0000_0000, 32'h0, 32'hFFFF_FFFF, 32'h0,         1'b0, 32'h4, 32'h0},
        '{64'h0000_0004_0000_0000, 32'h4, 32'h0,         32'h0,         1'b1, 32'h4, 32'h0}
    };

    initial begin
        fork
            begin
                #3_000_000;
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        join_none

        // R10: reset state
        do_reset();
        chk("R10 irq after reset", {31'b0, irq_out}, 32'h0);
        rd(12'h014, v); chk("R10 mask0 reset", v, 32'h0);
        rd(12'h02C, v); chk("R10 levels1 reset", v, 32'h0);

        // Table walk: R1 R3 R4 R5 R6 R7
        foreach (VECS[i]) begin
            do_reset();
            irq_in = VECS[i].pin;
            @(negedge clk); @(negedge clk);
            wr(12'h014, VECS[i].m0);
            wr(12'h024, VECS[i].m1);
            wr(12'h028, VECS[i].ack1);
            @(negedge clk); @(negedge clk);
            chk($sformatf("R6 vec%0d irq", i), {31'b0, irq_out}, {31'b0, VECS[i].exp_irq});
            rd(12'h010, v); chk($sformatf("R1 vec%0d events0", i), v, VECS[i].exp_ev0);
            rd(12'h020, v); chk($sformatf("R3 vec%0d events1", i), v, VECS[i].exp_ev1);
        end

        // R2: levels readout maps lines to banks
        do_reset();
        irq_in = 64'h8000_0001_0000_0002;
        @(negedge clk);
        rd(12'h01C, v); chk("R2 levels0", v, 32'h8000_0001);
        rd(12'h02C, v); chk("R2 levels1", v, 32'h0000_0002);

        // R3: the event is kept after the input falls
        do_reset();
        irq_in[0] = 1; @(negedge clk); @(negedge clk);
        irq_in[0] = 0; @(negedge clk); @(negedge clk);
        rd(12'h020, v); chk("R3 held after fall", v, 32'h1);

        // R4: an edge in the same cycle as the ack wins
        wr(12'h028, 32'h1);
        rd(12'h020, v); chk("R4 plain ack", v, 32'h0);
        irq_in[0] = 0; @(negedge clk);
        irq_in[0] = 1; @(negedge clk);
        irq_in[0] = 0; @(negedge clk);
        irq_in[0] = 1; addr = 12'h028; wdata = sw(32'h1); we = 1;
        @(negedge clk); we = 0;
        rd(12'h020, v); chk("R4 edge beats ack", v, 32'h1);

        // R7 and R8: mask latency, swapped mask selects level bit 24
        do_reset();
        irq_in[24] = 1; @(negedge clk);
        addr = 12'h024; wdata = 32'h0000_0001; we = 1;
        @(negedge clk); we = 0;
        chk("R7 irq one cycle after mask write", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R8 swapped mask enables bit24", {31'b0, irq_out}, 32'h1);
        rd(12'h024, v); chk("R8 mask read swap", v, 32'h0100_0000);
        addr = 12'h024; re = 1; #1;
        chk("R8 raw bus bytes", rdata, 32'h0000_0001);
        @(negedge clk); re = 0;
        // R5: ack does not clear a level bit
        wr(12'h028, 32'h0100_0000);
        @(negedge clk);
        chk("R5 level survives ack", {31'b0, irq_out}, 32'h1);
        irq_in[24] = 0; @(negedge clk); @(negedge clk);
        chk("R5 level drop lowers irq", {31'b0, irq_out}, 32'h0);

        // R9: bad addresses and offsets
        wr(12'h034, 32'hFFFF_FFFF);
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h014, v); chk("R9 mask0 untouched", v, 32'h0);
        rd(12'h034, v); chk("R9 bad bank read", v, 32'h0);
        rd(12'h004, v); chk("R9 low addr read", v, 32'h0);
        rd(12'h028, v); chk("R9 ack offset reads zero", v, 32'h0);
        rd(12'h025, v); chk("R9 odd offset reads zero", v, 32'h0);
        addr = 12'h024; re = 0; #1;
        chk("R9 rdata zero without re", rdata, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule